// File: doc/BRIEF.md
# SPI Transaction Sequencer

This block runs one complete SPI transaction around an external byte serializer. Software loads outgoing data into a word-wide transmit FIFO, then writes a command word that names a chip select and a byte count. The sequencer asserts that chip select and keeps it asserted for the whole count. It takes bytes out of the transmit words one at a time and hands each to the serializer. It collects the returned bytes into words for the receive FIFO. When the last byte has been stored it releases chip select and sets a done flag.

Software drives the block through a small register port with five locations: mode, command, event, transmit data and receive data. The event register combines live FIFO flags, an exact count of the received bytes waiting to be read, and sticky flags that software clears by writing 1. Clearing the enable bit aborts a transaction in flight and empties both FIFOs.

Top module: `spi_txn_seq`

## Requirements
- R1: After reset every chip select output is high (inactive), the mode register reads 0, the event register reads 0x0000_0100, and a read of receive data returns 0.
- R2: The mode register (address 0) stores the enable in bit 31, a 6-bit transmit threshold in bits 13:8 and a 6-bit receive threshold in bits 5:0. It reads these back, and all its other bits read 0.
- R3: A write to the command register (address 1) starts a transaction when the block is enabled and idle. The chip select number is taken from bits 31:30 and the byte count minus one from bits 15:0. The matching active-low select goes low in the cycle after the write and stays low until the last byte has been stored. A command is ignored when the block is disabled, when a transaction is already running, or when bits 15:0 exceed 0xFFEF.
- R4: Each transmit word written at address 3 is sent most significant byte first (bits 31:24 first). A transaction always starts at a word boundary, so bytes left unsent from the previous transaction's last word are discarded.
- R5: When a new word is needed and the transmit FIFO is empty, that whole word is sent as zero bytes.
- R6: Received bytes are packed with the first byte of each group of four in bits 31:24. The last word of a transaction holds the 1 to 3 leftover bytes left-aligned, with the unused low bytes zero. A read of address 4 returns the oldest word and removes it.
- R7: Event bits 29:24 give the exact number of received bytes held in the receive FIFO. Each stored word adds its own byte count, and each read of receive data subtracts the count of the word removed.
- R8: Event bit 8 is 1 while the 8-word transmit FIFO has room, and bit 9 is 1 while the 4-word receive FIFO holds data. A transmit write to a full FIFO is dropped, and a read of an empty receive FIFO returns 0.
- R9: Event bit 14 (done) is set when chip select is released at the end of a transaction. Event bit 15 (transmit empty) is set when the sequencer removes the last word from the transmit FIFO. Writing 1 to either bit clears it. Writing to bits 8, 9 or 29:24 has no effect.
- R10: Clearing the enable bit deasserts chip select at the same clock edge, aborts the transaction and empties both FIFOs. While disabled, both FIFOs stay empty and transmit writes are dropped.
- R11: When the receive FIFO is full and another word is ready, the sequencer stalls with chip select still asserted until software reads a word, and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops receive data at address 4) |
| reg_addr_i | input | 3 | Register address: 0 mode, 1 command, 2 event, 3 transmit data, 4 receive data |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| cs_n_o | output | 4 | Active-low chip selects |
| ser_valid_o | output | 1 | Byte offered to the serializer |
| ser_byte_o | output | 8 | Byte to shift out |
| ser_ready_i | input | 1 | Serializer accepts the offered byte |
| ser_rx_valid_i | input | 1 | Serializer returns the byte shifted in |
| ser_rx_byte_i | input | 8 | Returned byte |

## Verification
Register writes take effect at the clock edge that samples the strobe. The bench therefore checks chip select and the read values at the falling edge that follows each write. Event flags and the receive byte count update one cycle after the FIFO push or pop that causes them. The bench does not wait a fixed number of cycles for a transaction. It polls the event register until the done flag is set, and the serializer model inserts random delays of 0 to 2 cycles. Abort and back-pressure results are sampled after enough idle cycles for any reply still in flight to have arrived.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_CMD  = 3'd1,
    A_EVT  = 3'd2,
    A_TXD  = 3'd3,
    A_RXD  = 3'd4
  } reg_addr_e;

  localparam int EV_TNF     = 8;
  localparam int EV_RNE     = 9;
  localparam int EV_DON     = 14;
  localparam int EV_TXE     = 15;
  localparam int EV_CNT_LSB = 24;
  localparam int MODE_EN    = 31;
  localparam int CMD_CS_LSB = 30;
  localparam logic [15:0] MAX_LEN_M1 = 16'hFFEF;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SEND, S_WAIT, S_PUSH
  } seq_state_e;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rptr];
  assign count_o = count;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else if (flush_i) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  assert_drop_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(count));
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int CS_BITS = 2,
  parameter int LEN_W   = 16,
  localparam int NCS    = 1 << CS_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               start_i,
  input  logic [CS_BITS-1:0] cs_idx_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic [31:0]        tx_word_i,
  input  logic               tx_empty_i,
  output logic               tx_pop_o,
  output logic [31:0]        rx_word_o,
  output logic [2:0]         rx_nbytes_o,
  output logic               rx_push_o,
  input  logic               rx_full_i,
  output logic               done_o,
  output logic [NCS-1:0]     cs_n_o,
  output logic               ser_valid_o,
  output logic [7:0]         ser_byte_o,
  input  logic               ser_ready_i,
  input  logic               ser_rx_valid_i,
  input  logic [7:0]         ser_rx_byte_i
);
  seq_state_e state;
  logic [CS_BITS-1:0] cs_sel;
  logic [LEN_W-1:0]   rem_m1;
  logic [31:0]        tx_shift, rx_shift;
  logic [1:0]         tx_idx;
  logic [2:0]         rx_idx;
  logic               last_q;

  assign tx_pop_o    = (state == S_FETCH) && (tx_idx == 2'd0) && !tx_empty_i;
  assign ser_valid_o = (state == S_SEND);
  assign ser_byte_o  = tx_shift[31:24];
  assign rx_push_o   = (state == S_PUSH) && !rx_full_i;
  assign rx_word_o   = rx_shift;
  assign rx_nbytes_o = rx_idx;
  assign done_o      = rx_push_o && last_q;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n_o[i] = !((state != S_IDLE) && (cs_sel == CS_BITS'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; cs_sel <= '0; rem_m1 <= '0; tx_shift <= '0;
      rx_shift <= '0; tx_idx <= '0; rx_idx <= '0; last_q <= 1'b0;
    end else if (abort_i) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          state <= S_FETCH; cs_sel <= cs_idx_i; rem_m1 <= len_m1_i;
          tx_idx <= '0; rx_idx <= '0; rx_shift <= '0; last_q <= 1'b0;
        end
        S_FETCH: begin
          if (tx_idx == 2'd0) tx_shift <= tx_empty_i ? '0 : tx_word_i;
          state <= S_SEND;
        end
        S_SEND: if (ser_ready_i) begin
          tx_shift <= {tx_shift[23:0], 8'h00};
          tx_idx   <= tx_idx + 2'd1;
          state    <= S_WAIT;
        end
        S_WAIT: if (ser_rx_valid_i) begin
          rx_shift <= rx_shift | ({ser_rx_byte_i, 24'h0} >> {rx_idx[1:0], 3'b000});
          rx_idx   <= rx_idx + 3'd1;
          last_q   <= (rem_m1 == '0);
          if (rem_m1 != '0) rem_m1 <= rem_m1 - LEN_W'(1);
          state    <= ((rem_m1 == '0) || (rx_idx == 3'd3)) ? S_PUSH : S_FETCH;
        end
        S_PUSH: if (!rx_full_i) begin
          rx_shift <= '0;
          rx_idx   <= '0;
          state    <= last_q ? S_IDLE : S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  assert_valid_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> (cs_n_o != '1));
  assert_byte_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_o && !ser_ready_i) |=> (!ser_valid_o || $stable(ser_byte_o)));
endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
  import spi_seq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 4,
  parameter int CS_BITS  = 2,
  localparam int NCS     = 1 << CS_BITS,
  localparam int TXC_W   = $clog2(TX_DEPTH + 1),
  localparam int RXC_W   = $clog2(RX_DEPTH + 1),
  localparam int CNT_W   = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic           reg_re_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic [NCS-1:0] cs_n_o,
  output logic           ser_valid_o,
  output logic [7:0]     ser_byte_o,
  input  logic           ser_ready_i,
  input  logic           ser_rx_valid_i,
  input  logic [7:0]     ser_rx_byte_i
);
  logic en_q, done_q, txe_q;
  logic [5:0] txthr_q, rxthr_q;
  logic [CNT_W-1:0] rx_bytes;

  logic wr_mode, wr_cmd, wr_evt, wr_txd, rd_rxd, abort, flush, start;
  assign wr_mode = reg_we_i && (reg_addr_i == A_MODE);
  assign wr_cmd  = reg_we_i && (reg_addr_i == A_CMD);
  assign wr_evt  = reg_we_i && (reg_addr_i == A_EVT);
  assign wr_txd  = reg_we_i && (reg_addr_i == A_TXD);
  assign rd_rxd  = reg_re_i && (reg_addr_i == A_RXD);
  assign abort   = wr_mode && !reg_wdata_i[MODE_EN];
  assign flush   = abort || !en_q;
  assign start   = wr_cmd && en_q && (reg_wdata_i[15:0] <= MAX_LEN_M1);

  logic [31:0] tx_head;
  logic tx_full, tx_empty, tx_pop;
  logic [TXC_W-1:0] tx_count;
  logic [34:0] rx_head, rx_in;
  logic rx_full, rx_empty, rx_push;
  logic [RXC_W-1:0] unused_rx_count;
  logic [31:0] eng_rx_word;
  logic [2:0]  eng_rx_nb;
  logic eng_done;

  assign rx_in = {eng_rx_nb, eng_rx_word};

  spi_seq_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(wr_txd), .wdata_i(reg_wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty),
    .count_o(tx_count));

  spi_seq_fifo #(.W(35), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(rx_push), .wdata_i(rx_in),
    .pop_i(rd_rxd), .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty),
    .count_o(unused_rx_count));

  spi_seq_engine #(.CS_BITS(CS_BITS), .LEN_W(16)) u_engine (
    .clk_i, .rst_ni, .abort_i(abort), .start_i(start),
    .cs_idx_i(reg_wdata_i[CMD_CS_LSB +: CS_BITS]), .len_m1_i(reg_wdata_i[15:0]),
    .tx_word_i(tx_head), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
    .rx_word_o(eng_rx_word), .rx_nbytes_o(eng_rx_nb), .rx_push_o(rx_push),
    .rx_full_i(rx_full), .done_o(eng_done), .cs_n_o(cs_n_o),
    .ser_valid_o, .ser_byte_o, .ser_ready_i, .ser_rx_valid_i, .ser_rx_byte_i);

  logic rx_pop_ok, txe_set;
  logic [CNT_W-1:0] add_b, sub_b;
  assign rx_pop_ok = rd_rxd && !rx_empty;
  assign add_b   = rx_push ? CNT_W'(eng_rx_nb) : '0;
  assign sub_b   = rx_pop_ok ? CNT_W'(rx_head[34:32]) : '0;
  assign txe_set = tx_pop && !flush && (tx_count == TXC_W'(1)) && !wr_txd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; txthr_q <= '0; rxthr_q <= '0;
      done_q <= 1'b0; txe_q <= 1'b0; rx_bytes <= '0;
    end else begin
      if (wr_mode) begin
        en_q    <= reg_wdata_i[MODE_EN];
        txthr_q <= reg_wdata_i[13:8];
        rxthr_q <= reg_wdata_i[5:0];
      end
      rx_bytes <= flush ? '0 : rx_bytes + add_b - sub_b;
      // set wins over a same-cycle write-1 clear
      done_q <= eng_done || (done_q && !(wr_evt && reg_wdata_i[EV_DON]));
      txe_q  <= txe_set  || (txe_q  && !(wr_evt && reg_wdata_i[EV_TXE]));
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_MODE: reg_rdata_o = {en_q, 17'h0, txthr_q, 2'b00, rxthr_q};
      A_EVT: begin
        reg_rdata_o[EV_CNT_LSB +: CNT_W] = rx_bytes;
        reg_rdata_o[EV_TNF] = !tx_full;
        reg_rdata_o[EV_RNE] = !rx_empty;
        reg_rdata_o[EV_DON] = done_q;
        reg_rdata_o[EV_TXE] = txe_q;
      end
      A_RXD:   reg_rdata_o = rx_empty ? '0 : rx_head[31:0];
      default: reg_rdata_o = '0;
    endcase
  end

  assert_cs_off_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (cs_n_o == '1));
  assert_rxcnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bytes <= CNT_W'(4 * RX_DEPTH));
  assert_done_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (cs_n_o == '1));
endmodule

// File: tb/spi_txn_seq_test.sv
module spi_txn_seq_test;
  localparam logic [2:0] AM = 3'd0, AC = 3'd1, AE = 3'd2, AT = 3'd3, AR = 3'd4;
  localparam logic [31:0] EN = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] cs_n;
  logic ser_valid, ser_ready = 0, ser_rx_valid = 0;
  logic [7:0] ser_byte, ser_rx_byte = '0;

  int checks = 0, errors = 0;
  logic [7:0]  sent [0:63];
  int nsent = 0;
  bit cs_bad = 0;
  logic [3:0]  exp_cs_n = 4'hF;
  logic [31:0] pw [0:8];
  int exp_nw = 0;
  logic [31:0] rxw [0:15];
  int nrx = 0;

  always #2.5 clk = ~clk;

  spi_txn_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cs_n_o(cs_n),
    .ser_valid_o(ser_valid), .ser_byte_o(ser_byte), .ser_ready_i(ser_ready),
    .ser_rx_valid_i(ser_rx_valid), .ser_rx_byte_i(ser_rx_byte));

  // serializer model: returns each sent byte xor 8'h5A
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (ser_valid && ($urandom % 3) != 0) begin
        ser_ready = 1; b = ser_byte;
        if (nsent < 64) sent[nsent] = b;
        nsent++;
        if (cs_n !== exp_cs_n) cs_bad = 1;
        @(negedge clk); ser_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        ser_rx_valid = 1; ser_rx_byte = b ^ 8'h5A;
        @(negedge clk); ser_rx_valid = 0;
      end
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_sim();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  function automatic logic [7:0] expb(int k);
    int j = k / 4;
    if (j < exp_nw) return 8'(pw[j] >> (24 - 8 * (k % 4)));
    return 8'h00;
  endfunction

  function automatic logic [31:0] expw(int j, int len);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * j + b < len) w |= 32'(expb(4 * j + b) ^ 8'h5A) << (24 - 8 * b);
    return w;
  endfunction

  task automatic start_txn(int cs, int len, int npush);
    for (int i = 0; i < npush; i++) wr(AT, pw[i]);
    wr(AE, 32'hFFFF_FFFF);
    nsent = 0; cs_bad = 0; nrx = 0;
    exp_cs_n = ~(4'b0001 << cs);
    wr(AC, (32'(cs) << 30) | 32'(len - 1));
    chk("R3 cs asserted", {28'h0, cs_n}, {28'h0, exp_cs_n});
  endtask

  task automatic finish_txn(int len);
    logic [31:0] ev, d;
    int guard = 0;
    forever begin
      rd(AE, ev);
      if (ev[29:24] != 0) begin
        rd(AR, d);
        if (nrx < 16) rxw[nrx] = d;
        nrx++;
      end else if (ev[14]) break;
      guard++;
      if (guard > 3000) break;
    end
    chk("R3 byte count", nsent, len);
    for (int k = 0; k < len && k < 64; k++)
      chk((k / 4 < exp_nw) ? "R4 tx byte" : "R5 zero fill", sent[k], expb(k));
    chk("R6 rx words", nrx, (len + 3) / 4);
    for (int j = 0; j < nrx && j < 16; j++) chk("R6 rx word", rxw[j], expw(j, len));
    chk("R3 cs released", {28'h0, cs_n}, 32'hF);
    chk("R3 cs held", 32'(cs_bad), 0);
  endtask

  task automatic wait_done();
    logic [31:0] ev;
    for (int i = 0; i < 500; i++) begin
      rd(AE, ev);
      if (ev[14]) break;
    end
  endtask

  task automatic reenable();
    wr(AM, 32'h0);
    wr(AM, EN | 32'h0000_0403);
    exp_nw = 0;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs", {28'h0, cs_n}, 32'hF);
    rd(AE, d); chk("R1 event", d, 32'h0000_0100);
    rd(AM, d); chk("R1 mode", d, 32'h0);
    rd(AR, d); chk("R1 rx empty read", d, 32'h0);

    // R2 mode fields
    wr(AM, 32'h1234_0A05); rd(AM, d); chk("R2 mode", d, 32'h0000_0A05);
    wr(AM, 32'hFFFF_FFFF); rd(AM, d); chk("R2 mode", d, 32'h8000_3F3F);
    reenable();

    // directed: 7 bytes, two words, no reads during (R7, R9)
    pw[0] = 32'h1122_3344; pw[1] = 32'hA1B2_C3D4; exp_nw = 2;
    start_txn(2, 7, 2);
    wait_done();
    rd(AE, d);
    chk("R7 rx count", 32'(d[29:24]), 7);
    chk("R8 rne", 32'(d[9]), 1);
    chk("R9 done", 32'(d[14]), 1);
    chk("R9 txe", 32'(d[15]), 1);
    chk("R3 cs released", {28'h0, cs_n}, 32'hF);
    chk("R3 byte count", nsent, 7);
    for (int k = 0; k < 7; k++) chk("R4 tx byte", sent[k], expb(k));
    rd(AR, d); chk("R6 rx word", d, expw(0, 7));
    rd(AE, d); chk("R7 rx count after pop", 32'(d[29:24]), 3);
    rd(AR, d); chk("R6 partial word", d, expw(1, 7));
    rd(AE, d); chk("R7 rx count empty", 32'(d[29:24]), 0);
    wr(AE, 32'h0000_4300);
    rd(AE, d); chk("R9 w1c done only", d, 32'h0000_8100);
    wr(AE, 32'h0000_8000);
    rd(AE, d); chk("R9 w1c txe", d, 32'h0000_0100);

    // R5 zero fill
    exp_nw = 0; start_txn(0, 5, 0); finish_txn(5);

    // R4 leftover bytes discarded
    pw[0] = 32'hCAFE_F00D; exp_nw = 1; start_txn(1, 2, 1); finish_txn(2);
    pw[0] = 32'h0BAD_BEEF; exp_nw = 1; start_txn(3, 4, 1); finish_txn(4);

    // R3 ignored commands: too long, then busy
    wr(AC, 32'h0000_FFF0); repeat (10) @(negedge clk);
    chk("R3 overlong ignored", {28'h0, cs_n}, 32'hF);
    wr(AC, 32'h4000_FFEF);
    chk("R3 max length accepted", {28'h0, cs_n}, 32'hD);
    reenable(); repeat (10) @(negedge clk);
    exp_nw = 0; start_txn(0, 8, 0);
    wr(AC, 32'h8000_0002);
    finish_txn(8);

    // R8 transmit full drop
    reenable();
    for (int i = 0; i < 8; i++) begin pw[i] = $urandom; wr(AT, pw[i]); end
    rd(AE, d); chk("R8 tnf when full", 32'(d[8]), 0);
    wr(AT, 32'hDEAD_BEEF);
    exp_nw = 8; start_txn(1, 36, 0); finish_txn(36);

    // R11 receive back-pressure
    reenable();
    start_txn(1, 18, 0);
    repeat (300) @(negedge clk);
    chk("R11 cs held while stalled", {28'h0, cs_n}, 32'hD);
    rd(AE, d);
    chk("R11 count full", 32'(d[29:24]), 16);
    chk("R11 not done", 32'(d[14]), 0);
    chk("R11 bytes sent", nsent, 18);
    rd(AR, d); chk("R11 first word", d, 32'h5A5A_5A5A);
    repeat (10) @(negedge clk);
    rd(AE, d);
    chk("R11 count after resume", 32'(d[29:24]), 14);
    chk("R11 done", 32'(d[14]), 1);
    for (int j = 1; j < 5; j++) begin
      rd(AR, d); chk("R11 word", d, (j == 4) ? 32'h5A5A_0000 : 32'h5A5A_5A5A);
    end

    // R10 disable aborts and flushes
    pw[0] = 32'h0102_0304; pw[1] = 32'h0506_0708;
    exp_nw = 2; start_txn(3, 40, 2);
    repeat (40) @(negedge clk);
    wr(AM, 32'h0);
    chk("R10 cs released", {28'h0, cs_n}, 32'hF);
    rd(AE, d); chk("R10 flushed", d & 32'h3F00_0300, 32'h0000_0100);
    wr(AT, 32'h7777_7777);
    wr(AC, 32'h0000_0003);
    repeat (10) @(negedge clk);
    chk("R3 disabled cmd ignored", {28'h0, cs_n}, 32'hF);
    rd(AR, d); chk("R8 rx empty read", d, 32'h0);
    wr(AM, EN);
    exp_nw = 0; start_txn(2, 4, 0); finish_txn(4);

    // random transactions
    for (int it = 0; it < 12; it++) begin
      int len, cs;
      reenable();
      exp_nw = $urandom % 9;
      for (int i = 0; i < exp_nw; i++) pw[i] = $urandom;
      len = 1 + ($urandom % 32);
      cs = $urandom % 4;
      start_txn(cs, len, exp_nw);
      finish_txn(len);
    end

    finish_sim();
  end
endmodule